// File: doc/BRIEF.md
# Chained Vector Load and Scale Unit

This block carries out one convoy made of a vector load followed by a scalar multiply, with the two steps chained. A start pulse latches a scalar factor and a vector length. The block then asks an external element source for words at indices 0, 1, 2 and so on, one index per clock. Each word comes back through a fixed twelve-stage load latency. As soon as a word leaves the load path, it enters a seven-stage multiplier. The multiplier does not wait for the rest of the vector to arrive. Each product lands in a 32-entry destination register file.

Because the multiplier takes every element as it comes out of the load path, the two startup latencies add up only once. A full 32-element vector therefore completes in 12 + 7 + 32 = 51 cycles. A cycle counter is brought out so that this timing can be checked at the ports. The multiply is a 64-bit integer multiply that keeps the low half of the product.

Top module: `vec_chain_scale`

## Requirements
- R1: After reset, `busy_o` and `done_o` are low, `cycles_o` is 0 and every destination entry reads 0.
- R2: On an accepted start, the block drives `mem_rd_o` high for exactly len consecutive cycles, beginning in the cycle right after the start edge. During these cycles `mem_idx_o` counts up from 0 by one each cycle.
- R3: For every index k below len, destination entry k becomes the low 64 bits of (source word k × latched scalar).
- R4: Destination entries at index len and above keep their previous contents.
- R5: For len ≥ 1, `done_o` is a one-cycle pulse on the 19+len-th rising edge after the start edge. `busy_o` is high from the start edge until that edge and falls together with the pulse.
- R6: `cycles_o` counts the rising edges from the start edge to the done edge. It holds that value (19+len, or 1 for len 0) until the next accepted start.
- R7: A len of 0 raises `done_o` on the first edge after start, issues no read and writes no entry.
- R8: A start pulse that arrives while `busy_o` is high is ignored: the running scalar, length, results and timing are unaffected.
- R9: Entry k is written on edge 19+k after start. For len of 20 or more, entry 0 therefore changes while reads are still being issued, and it is unchanged one edge before that.
- R10: A len input above 32 is treated as 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| scalar_i | input | 64 | Scalar factor, latched at start |
| len_i | input | 6 | Vector length 0..32, larger values clamped |
| mem_rd_o | output | 1 | Element read request this cycle |
| mem_idx_o | output | 5 | Element index requested |
| mem_data_i | input | 64 | Source word for `mem_idx_o`, same cycle |
| rd_idx_i | input | 5 | Destination entry to read |
| rd_data_o | output | 64 | Destination entry contents (combinational) |
| busy_o | output | 1 | Convoy in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cycles_o | output | 6 | Edges from start to done |

## Verification
Runs use random scalars, random lengths and a different source-word pattern for each run. This separates a correct element-to-index pairing from a shifted or reused one. It also tells a true low-half product apart from a truncated or sign-extended one. Directed runs cover lengths 0, 1, 32 and an oversize value, which expose off-by-one errors in the issue count, the drain detection and the clamp. Runs with a start pulse injected mid-convoy show whether the running state is protected. Long runs sample entry 0 one edge before and at edge 19, which shows that results overlap the fetch instead of waiting for it.

// File: rtl/vcs_pkg.sv
package vcs_pkg;
  localparam int VCS_ELEM_W   = 64;
  localparam int VCS_DEPTH    = 32;
  localparam int VCS_LOAD_LAT = 12;
  localparam int VCS_MUL_LAT  = 7;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/vcs_load_pipe.sv
// Element fetch: issues one index per cycle, then delays each word by LAT stages.
module vcs_load_pipe #(
  parameter int ELEM_W = 64,
  parameter int IDX_W  = 5,
  parameter int LEN_W  = 6,
  parameter int LAT    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  logic              active_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ELEM_W-1:0] mem_data_i,
  output logic              mem_rd_o,
  output logic [IDX_W-1:0]  mem_idx_o,
  output logic              issue_done_o,
  output logic              pipe_busy_o,
  output logic              out_vld_o,
  output logic [ELEM_W-1:0] out_data_o,
  output logic [IDX_W-1:0]  out_idx_o
);
  logic [LEN_W-1:0]  issue_cnt;
  logic              vld_q [LAT];
  logic [ELEM_W-1:0] dat_q [LAT];
  logic [IDX_W-1:0]  idx_q [LAT];
  logic [LAT-1:0]    vld_vec;

  assign issue_done_o = (issue_cnt >= len_i);
  assign mem_rd_o     = active_i && !issue_done_o;
  assign mem_idx_o    = issue_cnt[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        issue_cnt <= '0;
    else if (launch_i) issue_cnt <= '0;
    else if (mem_rd_o) issue_cnt <= issue_cnt + LEN_W'(1);
  end

  for (genvar s = 0; s < LAT; s++) begin : g_stage
    assign vld_vec[s] = vld_q[s];
    if (s == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q[0] <= 1'b0;
          dat_q[0] <= '0;
          idx_q[0] <= '0;
        end else begin
          vld_q[0] <= mem_rd_o;
          dat_q[0] <= mem_data_i;
          idx_q[0] <= mem_idx_o;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q[s] <= 1'b0;
          dat_q[s] <= '0;
          idx_q[s] <= '0;
        end else begin
          vld_q[s] <= vld_q[s-1];
          dat_q[s] <= dat_q[s-1];
          idx_q[s] <= idx_q[s-1];
        end
      end
    end
  end

  assign pipe_busy_o = |vld_vec;
  assign out_vld_o   = vld_q[LAT-1];
  assign out_data_o  = dat_q[LAT-1];
  assign out_idx_o   = idx_q[LAT-1];
endmodule

// File: rtl/vcs_mul_pipe.sv
// Scalar multiply: the product is formed into the first of STAGES registers;
// the destination write is the final stage of the multiply latency.
module vcs_mul_pipe #(
  parameter int ELEM_W = 64,
  parameter int IDX_W  = 5,
  parameter int STAGES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ELEM_W-1:0] scalar_i,
  input  logic              in_vld_i,
  input  logic [ELEM_W-1:0] in_data_i,
  input  logic [IDX_W-1:0]  in_idx_i,
  output logic              pipe_busy_o,
  output logic              out_vld_o,
  output logic [ELEM_W-1:0] out_data_o,
  output logic [IDX_W-1:0]  out_idx_o
);
  function automatic logic [ELEM_W-1:0] scale_elem(input logic [ELEM_W-1:0] a,
                                                   input logic [ELEM_W-1:0] b);
    return a * b;
  endfunction

  logic              vld_q [STAGES];
  logic [ELEM_W-1:0] dat_q [STAGES];
  logic [IDX_W-1:0]  idx_q [STAGES];
  logic [STAGES-1:0] vld_vec;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    assign vld_vec[s] = vld_q[s];
    if (s == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q[0] <= 1'b0;
          dat_q[0] <= '0;
          idx_q[0] <= '0;
        end else begin
          vld_q[0] <= in_vld_i;
          dat_q[0] <= scale_elem(in_data_i, scalar_i);
          idx_q[0] <= in_idx_i;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q[s] <= 1'b0;
          dat_q[s] <= '0;
          idx_q[s] <= '0;
        end else begin
          vld_q[s] <= vld_q[s-1];
          dat_q[s] <= dat_q[s-1];
          idx_q[s] <= idx_q[s-1];
        end
      end
    end
  end

  assign pipe_busy_o = |vld_vec;
  assign out_vld_o   = vld_q[STAGES-1];
  assign out_data_o  = dat_q[STAGES-1];
  assign out_idx_o   = idx_q[STAGES-1];
endmodule

// File: rtl/vcs_dest_regs.sv
// Destination register file: one write port, one combinational read port.
module vcs_dest_regs #(
  parameter int ELEM_W = 64,
  parameter int DEPTH  = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ELEM_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [ELEM_W-1:0] rd_data_o
);
  logic [ELEM_W-1:0] entry_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     entry_q[e] <= '0;
      else if (wr_en_i && (wr_idx_i == IDX_W'(e)))    entry_q[e] <= wr_data_i;
    end
  end

  assign rd_data_o = entry_q[rd_idx_i];
endmodule

// File: rtl/vec_chain_scale.sv
module vec_chain_scale
  import vcs_pkg::*;
#(
  parameter  int ELEM_W   = VCS_ELEM_W,
  parameter  int DEPTH    = VCS_DEPTH,
  parameter  int LOAD_LAT = VCS_LOAD_LAT,
  parameter  int MUL_LAT  = VCS_MUL_LAT,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int LEN_W    = $clog2(DEPTH + 1),
  localparam int CYC_W    = $clog2(LOAD_LAT + MUL_LAT + DEPTH + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ELEM_W-1:0] scalar_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              mem_rd_o,
  output logic [IDX_W-1:0]  mem_idx_o,
  input  logic [ELEM_W-1:0] mem_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [ELEM_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [CYC_W-1:0]  cycles_o
);
  run_state_e        state_q;
  logic              done_q;
  logic [CYC_W-1:0]  cyc_q;
  logic [LEN_W-1:0]  len_q;
  logic [ELEM_W-1:0] scalar_q;
  logic [LEN_W-1:0]  len_clamp;

  // Named internal events for the checker
  logic              start_ok;
  logic              drain;
  logic              ld_issue_done, ld_busy, ld_vld;
  logic [ELEM_W-1:0] ld_data;
  logic [IDX_W-1:0]  ld_idx;
  logic              mul_busy;
  logic              wr_en;
  logic [ELEM_W-1:0] wr_data;
  logic [IDX_W-1:0]  wr_idx;

  assign busy_o    = (state_q == ST_RUN);
  assign start_ok  = start_i && (state_q == ST_IDLE);
  assign len_clamp = (len_i > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : len_i;
  assign drain     = busy_o && ld_issue_done && !ld_busy && !mul_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      done_q   <= 1'b0;
      cyc_q    <= '0;
      len_q    <= '0;
      scalar_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_ok) begin
        state_q  <= ST_RUN;
        len_q    <= len_clamp;
        scalar_q <= scalar_i;
        cyc_q    <= '0;
      end else if (busy_o) begin
        cyc_q <= cyc_q + CYC_W'(1);
        if (drain) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  assign done_o   = done_q;
  assign cycles_o = cyc_q;

  vcs_load_pipe #(
    .ELEM_W(ELEM_W), .IDX_W(IDX_W), .LEN_W(LEN_W), .LAT(LOAD_LAT)
  ) u_load (
    .clk(clk), .rst_n(rst_n),
    .launch_i(start_ok), .active_i(busy_o), .len_i(len_q),
    .mem_data_i(mem_data_i), .mem_rd_o(mem_rd_o), .mem_idx_o(mem_idx_o),
    .issue_done_o(ld_issue_done), .pipe_busy_o(ld_busy),
    .out_vld_o(ld_vld), .out_data_o(ld_data), .out_idx_o(ld_idx)
  );

  vcs_mul_pipe #(
    .ELEM_W(ELEM_W), .IDX_W(IDX_W), .STAGES(MUL_LAT - 1)
  ) u_mul (
    .clk(clk), .rst_n(rst_n), .scalar_i(scalar_q),
    .in_vld_i(ld_vld), .in_data_i(ld_data), .in_idx_i(ld_idx),
    .pipe_busy_o(mul_busy),
    .out_vld_o(wr_en), .out_data_o(wr_data), .out_idx_o(wr_idx)
  );

  vcs_dest_regs #(
    .ELEM_W(ELEM_W), .DEPTH(DEPTH), .IDX_W(IDX_W)
  ) u_dest (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o)
  );
endmodule

// File: rtl/vcs_checker.sv
module vcs_checker #(
  parameter int LOAD_LAT = 12,
  parameter int MUL_LAT  = 7,
  parameter int DEPTH    = 32,
  parameter int LEN_W    = 6,
  parameter int IDX_W    = 5,
  parameter int CYC_W    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_o,
  input logic             done_o,
  input logic [CYC_W-1:0] cycles_o,
  input logic             mem_rd_o,
  input logic [IDX_W-1:0] mem_idx_o,
  input logic [LEN_W-1:0] len_q,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx
);
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_busy_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  assert_cycle_total_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (int'(cycles_o) ==
                ((len_q == '0) ? 1 : LOAD_LAT + MUL_LAT + int'(len_q))));

  assert_write_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < int'(len_q)));

  assert_issue_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && $past(mem_rd_o)) |-> (mem_idx_o == $past(mem_idx_o) + IDX_W'(1)));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(len_q));

  assert_no_read_len0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && (len_q == '0)) |-> !mem_rd_o);

  assert_len_clamp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(len_q) <= DEPTH);
endmodule

bind vec_chain_scale vcs_checker #(
  .LOAD_LAT(LOAD_LAT), .MUL_LAT(MUL_LAT), .DEPTH(DEPTH),
  .LEN_W(LEN_W), .IDX_W(IDX_W), .CYC_W(CYC_W)
) u_vcs_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o),
  .cycles_o(cycles_o), .mem_rd_o(mem_rd_o), .mem_idx_o(mem_idx_o),
  .len_q(len_q), .wr_en(wr_en), .wr_idx(wr_idx)
);

// File: tb/vec_chain_scale_bench.sv
module vec_chain_scale_bench;
  localparam int DEPTH  = 32;
  localparam int HALF_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] scalar_i = '0;
  logic [5:0]  len_i = '0;
  logic        mem_rd_o;
  logic [4:0]  mem_idx_o;
  logic [63:0] mem_data_i;
  logic [4:0]  rd_idx_i = '0;
  logic [63:0] rd_data_o;
  logic        busy_o, done_o;
  logic [5:0]  cycles_o;

  logic [31:0] pat = 32'h0;
  logic [63:0] exp_arr [DEPTH];
  int checks = 0;
  int fails  = 0;

  always #(HALF_NS) clk = ~clk;

  function automatic logic [63:0] mem_word(input logic [31:0] p, input logic [4:0] k);
    logic [31:0] kk;
    kk = {27'd0, k};
    return {p ^ (kk * 32'd977), kk * 32'h9E3779B9} ^ 64'hA5A5_0F0F_3C3C_5A5A;
  endfunction

  function automatic logic [63:0] ref_scale(input logic [63:0] a, input logic [63:0] b);
    logic [127:0] full;
    full = {64'd0, a} * {64'd0, b};
    return full[63:0];
  endfunction

  assign mem_data_i = mem_word(pat, mem_idx_o);

  vec_chain_scale u_vec_chain_scale (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .scalar_i(scalar_i),
    .len_i(len_i), .mem_rd_o(mem_rd_o), .mem_idx_o(mem_idx_o),
    .mem_data_i(mem_data_i), .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o),
    .busy_o(busy_o), .done_o(done_o), .cycles_o(cycles_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_case(input logic [63:0] sc, input int ln, input logic [31:0] p,
                          input bit poke);
    int el, total;
    logic [63:0] old0, new0;
    bit r2_bad, r5_bad, r9_bad;
    logic [63:0] r2_act, r2_exp, r5_act, r5_exp;
    el    = (ln > DEPTH) ? DEPTH : ln;
    total = (el == 0) ? 1 : 19 + el;
    old0  = exp_arr[0];
    new0  = (el > 0) ? ref_scale(mem_word(p, 5'd0), sc) : old0;
    r2_bad = 0; r5_bad = 0; r9_bad = 0;
    r2_act = '0; r2_exp = '0; r5_act = '0; r5_exp = '0;
    @(negedge clk);
    pat = p; scalar_i = sc; len_i = 6'(ln); rd_idx_i = 5'd0; start_i = 1'b1;
    for (int n = 0; n <= total + 1; n++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (poke && n == 5) begin
        start_i = 1'b1; scalar_i = ~sc; len_i = 6'd3;
      end
      // R2: read stream
      if (mem_rd_o !== (n < el) || (mem_rd_o && mem_idx_o !== 5'(n))) begin
        if (!r2_bad) begin
          r2_act = {58'd0, mem_rd_o, mem_idx_o};
          r2_exp = {58'd0, 1'(n < el), 5'(n)};
        end
        r2_bad = 1;
      end
      // R5 / R7: busy and done timing
      if (busy_o !== (n < total) || done_o !== (n == total)) begin
        if (!r5_bad) begin
          r5_act = {32'(n), 30'd0, busy_o, done_o};
          r5_exp = {32'(n), 30'd0, 1'(n < total), 1'(n == total)};
        end
        r5_bad = 1;
      end
      // R9: overlap of writes with fetch
      if (el >= 20 && n == 18 && rd_data_o !== old0) r9_bad = 1;
      if (el >= 20 && n == 19 && (rd_data_o !== new0 || mem_rd_o !== 1'b1)) r9_bad = 1;
    end
    chk(!r2_bad, (el == 0) ? "R7 no read on empty length" : "R2 read stream", r2_act, r2_exp);
    chk(!r5_bad, (el == 0) ? "R7 done after one edge" :
                 (poke ? "R8 timing with ignored start" : "R5 busy/done timing"), r5_act, r5_exp);
    chk(cycles_o == 6'(total), "R6 cycle count", {58'd0, cycles_o}, 64'(total));
    if (el >= 20) chk(!r9_bad, "R9 entry 0 written on edge 19", rd_data_o, new0);
    for (int k = 0; k < el; k++) exp_arr[k] = ref_scale(mem_word(p, 5'(k)), sc);
    for (int k = 0; k < DEPTH; k++) begin
      rd_idx_i = 5'(k);
      #1;
      if (k < el)
        chk(rd_data_o === exp_arr[k], poke ? "R8 result with ignored start" :
            (ln > DEPTH ? "R10 clamped result" : "R3 product"), rd_data_o, exp_arr[k]);
      else
        chk(rd_data_o === exp_arr[k], (el == 0) ? "R7 nothing written" : "R4 entry kept",
            rd_data_o, exp_arr[k]);
    end
  endtask

  initial begin
    int seed_init;
    seed_init = $urandom(32'h5EED_1234);
    for (int k = 0; k < DEPTH; k++) exp_arr[k] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy_o === 1'b0 && done_o === 1'b0, "R1 idle flags", {62'd0, busy_o, done_o}, 64'd0);
    chk(cycles_o === 6'd0, "R1 cycle count", {58'd0, cycles_o}, 64'd0);
    rd_idx_i = 5'd7; #1;
    chk(rd_data_o === 64'd0, "R1 entry cleared", rd_data_o, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run_case(64'd3, 32, 32'h1111_0001, 1'b0);
    run_case(64'hFFFF_FFFF_FFFF_FFFF, 5, 32'h2222_0002, 1'b0);
    run_case(64'd9, 0, 32'h3333_0003, 1'b0);
    run_case(64'h0123_4567_89AB_CDEF, 1, 32'h4444_0004, 1'b0);
    run_case(64'h8000_0000_0000_0001, 45, 32'h5555_0005, 1'b0);
    run_case(64'hDEAD_BEEF_0000_0007, 20, 32'h6666_0006, 1'b1);
    for (int r = 0; r < 10; r++) begin
      logic [63:0] sc;
      int ln;
      sc = {$urandom(), $urandom()};
      ln = int'($urandom_range(0, 33));
      run_case(sc, ln, $urandom(), (ln > 0) && ($urandom_range(0, 1) == 1));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule